// File: doc/BRIEF.md
# Display Window Border Latches

This block decides, pixel by pixel, whether the beam is inside the programmable display window of a raster display. It watches the horizontal pixel counter and the vertical line counter and compares them against stored window start and stop coordinates. The window is not computed as a range test. Two small state machines act as set/reset latches. The vertical latch tracks the top and bottom edges, and the horizontal latch tracks the left and right edges. Each one opens when its counter hits the start coordinate and closes when it hits the stop coordinate.

The window only clips pixel data that a separate fetch engine has already brought in. It does not start, stop, delay or shift that fetch. The window can be wider or narrower than the fetched interval, and its horizontal edges can sit on any single low-resolution pixel. The vertical flag is exported so that a fetch engine can limit its work to lines inside the window. The clip enable is the registered AND of both latches, one cycle behind them.

Each latch is a two-state machine with the states WIN_CLOSED and WIN_OPEN. It has three named transitions:
- T_SET goes from WIN_CLOSED to WIN_OPEN when the counter equals the start coordinate.
- T_STOP goes from WIN_OPEN to WIN_CLOSED when the counter equals the stop coordinate.
- T_FORCE goes from WIN_OPEN to WIN_CLOSED on a forced clear, unless the counter also equals the start coordinate.

The forced clear is the frame-start pulse for the vertical latch and pixel position 0 for the horizontal latch. Lines 0 to 24 are never opened. A vertical start below the first line allowed to open acts as that line, so the first line that can open is the larger of 25 and the programmed start.

Top module: `disp_window_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `v_win_o`, `h_win_o` and `clip_en_o` are 0.
- R2: When `vpos` equals the effective vertical start in a cycle where `v_win_o` is 0, `v_win_o` is 1 from the next cycle.
- R3: While `v_win_o` is 1, `vpos` equal to the vertical stop clears it in the next cycle. So does a `frame_start` pulse, unless `vpos` also equals the effective vertical start.
- R4: When `hpos` equals the horizontal start, `h_win_o` is 1 from the next cycle. This holds for any pixel value, with no 16-pixel alignment.
- R5: While `h_win_o` is 1, `hpos` equal to the horizontal stop clears it in the next cycle. `hpos` equal to 0 also clears it, unless the horizontal start is 0, in which case it stays set.
- R6: When start equals stop, the latch opens on the first match and stays open until the next match, which closes it.
- R7: A cycle with `start_we` loads `wr_h`/`wr_v` as the horizontal/vertical start, and a cycle with `stop_we` loads them as the stop. Compares in the write cycle still use the old value, and the new value is used from the next cycle.
- R8: `clip_en_o` in each cycle equals `v_win_o & h_win_o` of the previous cycle.
- R9: The effective vertical start is max(25, programmed start). A start below 25 opens the window on line 25 and not earlier.
- R10: The horizontal latch runs on every line whether the vertical latch is open or not. `clip_en_o` stays 0 while `v_win_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | HPOS_W | Current horizontal pixel position |
| vpos | input | VPOS_W | Current line number |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| start_we | input | 1 | Load `wr_h`/`wr_v` as window start |
| stop_we | input | 1 | Load `wr_h`/`wr_v` as window stop |
| wr_h | input | HPOS_W | Horizontal coordinate to write |
| wr_v | input | VPOS_W | Vertical coordinate to write |
| v_win_o | output | 1 | Vertical latch state (line is inside window) |
| h_win_o | output | 1 | Horizontal latch state |
| clip_en_o | output | 1 | Registered AND of both latches, pixel clip enable |

## Verification
The bench targets three corner cases.

- Equal start and stop. A design that gave the stop compare priority would never open. A design that cleared in the same cycle would produce no open interval at all.
- Horizontal start of 0. If the line-start clear beat the start compare, the window would flicker shut at every line start and never show its left column.
- A vertical start inside the blanking lines. A missing clamp would open the window on line 5 instead of 25.

The bench also writes a new start in the same cycle that the counter equals it. A design that compared against the incoming data instead of the held register would open one cycle early. Finally, it checks the clip enable one cycle behind both flags, at an odd-valued edge. An unregistered AND, or alignment to 16 pixels, shows up there as a one-cycle or multi-pixel offset.

// File: rtl/dw_pkg.sv
package dw_pkg;

    typedef enum logic {
        WIN_CLOSED = 1'b0,
        WIN_OPEN   = 1'b1
    } win_state_t;

endpackage

// File: rtl/dw_regs.sv
module dw_regs #(
    parameter int HPOS_W = 9,
    parameter int VPOS_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_we,
    input  logic              stop_we,
    input  logic [HPOS_W-1:0] wr_h,
    input  logic [VPOS_W-1:0] wr_v,
    output logic [HPOS_W-1:0] h_start,
    output logic [HPOS_W-1:0] h_stop,
    output logic [VPOS_W-1:0] v_start,
    output logic [VPOS_W-1:0] v_stop
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_start <= '0;
            v_start <= '0;
        end else if (start_we) begin
            h_start <= wr_h;
            v_start <= wr_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_stop <= '0;
            v_stop <= '0;
        end else if (stop_we) begin
            h_stop <= wr_h;
            v_stop <= wr_v;
        end
    end

    // R7: start coordinates visible in the cycle after the write
    assert_start_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_we |=> (h_start == $past(wr_h)) && (v_start == $past(wr_v)));

    // R7: stop coordinates visible in the cycle after the write
    assert_stop_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_we |=> (h_stop == $past(wr_h)) && (v_stop == $past(wr_v)));

endmodule

// File: rtl/dw_latch.sv
module dw_latch
    import dw_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] start_val,
    input  logic [POS_W-1:0] stop_val,
    input  logic             force_clr,
    output logic             open_o
);

    win_state_t state_q, state_d;
    logic       hit_start, hit_stop;

    assign hit_start = (pos == start_val);
    assign hit_stop  = (pos == stop_val);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_CLOSED;
        else        state_q <= state_d;
    end

    // next state: T_SET, T_STOP, T_FORCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_CLOSED: begin
                if (hit_start) state_d = WIN_OPEN;                      // T_SET
            end
            WIN_OPEN: begin
                if (hit_stop)                      state_d = WIN_CLOSED; // T_STOP
                else if (force_clr && !hit_start)  state_d = WIN_CLOSED; // T_FORCE
            end
            default: state_d = WIN_CLOSED;
        endcase
    end

    // outputs
    always_comb begin
        open_o = (state_q == WIN_OPEN);
    end

    // R2 / R4: a start match from the closed state opens the latch
    assert_set_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && hit_start) |=> open_o);

    // R3 / R5 / R6: a stop match from the open state closes the latch
    assert_clear_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && hit_stop) |=> !open_o);

    // R3 / R5: forced clear without a start match closes the latch
    assert_force_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && force_clr && !hit_start) |=> !open_o);

    // R2 / R4: the latch never opens without a start match
    assert_open_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(hit_start));

endmodule

// File: rtl/disp_window_gate.sv
module disp_window_gate #(
    parameter int HPOS_W     = 9,
    parameter int VPOS_W     = 9,
    parameter int FIRST_LINE = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [VPOS_W-1:0] vpos,
    input  logic              frame_start,
    input  logic              start_we,
    input  logic              stop_we,
    input  logic [HPOS_W-1:0] wr_h,
    input  logic [VPOS_W-1:0] wr_v,
    output logic              v_win_o,
    output logic              h_win_o,
    output logic              clip_en_o
);

    localparam logic [VPOS_W-1:0] V_FLOOR = VPOS_W'(FIRST_LINE);

    logic [HPOS_W-1:0] h_start, h_stop;
    logic [VPOS_W-1:0] v_start, v_stop, v_start_eff;
    logic              line_start;

    dw_regs #(.HPOS_W(HPOS_W), .VPOS_W(VPOS_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_we (start_we),
        .stop_we  (stop_we),
        .wr_h     (wr_h),
        .wr_v     (wr_v),
        .h_start  (h_start),
        .h_stop   (h_stop),
        .v_start  (v_start),
        .v_stop   (v_stop)
    );

    // blanking clamp: the first openable line is max(FIRST_LINE, start)
    assign v_start_eff = (v_start < V_FLOOR) ? V_FLOOR : v_start;
    assign line_start  = (hpos == '0);

    dw_latch #(.POS_W(VPOS_W)) u_vlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (vpos),
        .start_val (v_start_eff),
        .stop_val  (v_stop),
        .force_clr (frame_start),
        .open_o    (v_win_o)
    );

    dw_latch #(.POS_W(HPOS_W)) u_hlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pos       (hpos),
        .start_val (h_start),
        .stop_val  (h_stop),
        .force_clr (line_start),
        .open_o    (h_win_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) clip_en_o <= 1'b0;
        else        clip_en_o <= v_win_o & h_win_o;
    end

    // R8: clip enable trails both latches by one cycle
    assert_clip_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (clip_en_o == ($past(v_win_o) && $past(h_win_o))));

    // R9: the vertical window never opens inside the blanking lines
    assert_vblank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_win_o) |-> ($past(vpos) >= V_FLOOR));

    // R10: no clip while the vertical window is closed
    assert_clip_needs_v_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!v_win_o) |=> !clip_en_o);

    // R1: outputs quiet in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        (!rst_n) |=> (!v_win_o && !h_win_o && !clip_en_o));

endmodule

// File: tb/test_disp_window_gate.sv
module test_disp_window_gate;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [8:0] hpos, vpos, wr_h, wr_v;
    logic       frame_start, start_we, stop_we;
    logic       v_win_o, h_win_o, clip_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    disp_window_gate i_disp_window_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .hpos        (hpos),
        .vpos        (vpos),
        .frame_start (frame_start),
        .start_we    (start_we),
        .stop_we     (stop_we),
        .wr_h        (wr_h),
        .wr_v        (wr_v),
        .v_win_o     (v_win_o),
        .h_win_o     (h_win_o),
        .clip_en_o   (clip_en_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] h, input logic [8:0] v, input logic fs);
        @(negedge clk);
        hpos = h; vpos = v; frame_start = fs; start_we = 0; stop_we = 0;
        @(posedge clk); #1;
    endtask

    task automatic load(input logic is_start, input logic [8:0] dh, input logic [8:0] dv,
                        input logic [8:0] h, input logic [8:0] v);
        @(negedge clk);
        hpos = h; vpos = v; frame_start = 0;
        start_we = is_start; stop_we = !is_start; wr_h = dh; wr_v = dv;
        @(posedge clk); #1;
    endtask

    task automatic set_window(input logic [8:0] hs, input logic [8:0] vs,
                              input logic [8:0] he, input logic [8:0] ve);
        load(1'b1, hs, vs, 9'd511, 9'd511);
        load(1'b0, he, ve, 9'd511, 9'd511);
    endtask

    task automatic t_reset;
        rst_n = 0; hpos = 9'd511; vpos = 9'd511; frame_start = 0;
        start_we = 0; stop_we = 0; wr_h = 0; wr_v = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 v_win in reset", v_win_o, 1'b0);
        check("R1 h_win in reset", h_win_o, 1'b0);
        check("R1 clip in reset", clip_en_o, 1'b0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        check("R1 clip after reset", clip_en_o, 1'b0);
    endtask

    task automatic t_horizontal;
        set_window(9'd37, 9'd30, 9'd41, 9'd32);
        drive(9'd0, 9'd10, 1'b1);
        for (int k = 1; k <= 50; k++) begin
            drive(9'(k), 9'd10, 1'b0);
            if (k == 36) check("R4 before start", h_win_o, 1'b0);
            if (k == 37) check("R4 opens at odd pixel 37", h_win_o, 1'b1);
            if (k == 40) check("R5 still open at 40", h_win_o, 1'b1);
            if (k == 41) check("R5 closes at stop", h_win_o, 1'b0);
            if (k == 38) check("R10 no clip with v closed", clip_en_o, 1'b0);
        end
        check("R10 v stays closed", v_win_o, 1'b0);
    endtask

    task automatic t_vertical;
        drive(9'd0, 9'd0, 1'b1);
        drive(9'd5, 9'd29, 1'b0); check("R2 before start line", v_win_o, 1'b0);
        drive(9'd5, 9'd30, 1'b0); check("R2 opens at start line", v_win_o, 1'b1);
        drive(9'd5, 9'd31, 1'b0); check("R3 open inside", v_win_o, 1'b1);
        drive(9'd5, 9'd32, 1'b0); check("R3 closes at stop line", v_win_o, 1'b0);
        drive(9'd5, 9'd30, 1'b0); check("R2 reopens", v_win_o, 1'b1);
        drive(9'd5, 9'd0, 1'b1);  check("R3 frame start clears", v_win_o, 1'b0);
    endtask

    task automatic t_vblank;
        set_window(9'd37, 9'd5, 9'd41, 9'd40);
        drive(9'd0, 9'd0, 1'b1);
        drive(9'd5, 9'd5, 1'b0);  check("R9 no open at line 5", v_win_o, 1'b0);
        drive(9'd5, 9'd24, 1'b0); check("R9 no open at line 24", v_win_o, 1'b0);
        drive(9'd5, 9'd25, 1'b0); check("R9 opens at line 25", v_win_o, 1'b1);
    endtask

    task automatic t_clip;
        set_window(9'd37, 9'd30, 9'd41, 9'd32);
        drive(9'd0, 9'd0, 1'b1);
        drive(9'd0, 9'd30, 1'b0);
        drive(9'd37, 9'd30, 1'b0);
        check("R8 h open", h_win_o, 1'b1);
        check("R8 clip lags", clip_en_o, 1'b0);
        drive(9'd38, 9'd30, 1'b0); check("R8 clip on", clip_en_o, 1'b1);
        drive(9'd41, 9'd30, 1'b0);
        check("R8 h closed", h_win_o, 1'b0);
        check("R8 clip still on", clip_en_o, 1'b1);
        drive(9'd42, 9'd30, 1'b0); check("R8 clip off", clip_en_o, 1'b0);
    endtask

    task automatic t_line_start;
        set_window(9'd37, 9'd30, 9'd200, 9'd32);
        drive(9'd37, 9'd10, 1'b0); check("R5 open before line start", h_win_o, 1'b1);
        drive(9'd0, 9'd10, 1'b0);  check("R5 line start clears", h_win_o, 1'b0);
        set_window(9'd0, 9'd30, 9'd200, 9'd32);
        drive(9'd0, 9'd10, 1'b0);  check("R5 start 0 opens", h_win_o, 1'b1);
        drive(9'd5, 9'd10, 1'b0);
        drive(9'd0, 9'd10, 1'b0);  check("R5 start 0 survives line start", h_win_o, 1'b1);
    endtask

    task automatic t_equal;
        set_window(9'd50, 9'd30, 9'd50, 9'd32);
        drive(9'd0, 9'd10, 1'b0);  check("R6 closed by line start", h_win_o, 1'b0);
        drive(9'd50, 9'd10, 1'b0); check("R6 set wins on equal", h_win_o, 1'b1);
        drive(9'd51, 9'd10, 1'b0); check("R6 stays open", h_win_o, 1'b1);
        drive(9'd50, 9'd10, 1'b0); check("R6 next match closes", h_win_o, 1'b0);
    endtask

    task automatic t_write_timing;
        drive(9'd0, 9'd10, 1'b0);
        load(1'b1, 9'd60, 9'd30, 9'd60, 9'd10);
        check("R7 old start used in write cycle", h_win_o, 1'b0);
        drive(9'd60, 9'd10, 1'b0);
        check("R7 new start used next cycle", h_win_o, 1'b1);
        load(1'b0, 9'd61, 9'd32, 9'd61, 9'd10);
        check("R7 old stop used in write cycle", h_win_o, 1'b1);
        drive(9'd61, 9'd10, 1'b0);
        check("R7 new stop used next cycle", h_win_o, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_horizontal();
        t_vertical();
        t_vblank();
        t_clip();
        t_line_start();
        t_equal();
        t_write_timing();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule